// File: doc/BRIEF.md
# Byte-accessed 16-bit timer counter

This block is a 16-bit up-counter with an auto-reload limit. Software reaches it through an 8-bit register port with a byte address, a write strobe, a read strobe, write data and read data. The counter steps by one on each cycle where the count tick is high. When it sits at the active limit and a tick arrives, it returns to zero and raises a single-cycle update pulse.

Two byte-wide accesses stand in for one 16-bit access, and the block keeps them coherent. Reading the counter's high byte freezes the low byte in a holding latch, so the following low-byte read returns the value that belonged with that high byte, even after the counter has moved on. The limit is written into a staging register. Its copy into the active limit happens only at an update, and it is held off from the high-byte write until the low-byte write, so a half-written limit never takes effect.

Top module: `byte_timer16`

## Requirements
- R1: After reset the counter reads 0x0000, the limit staging register reads 0xFFFF, the active limit is 0xFFFF and `upd_evt` is low.
- R2: When `cnt_tick` is high, no counter byte is written and the counter differs from the active limit, the counter adds one at the clock edge. With `cnt_tick` low and no counter write, it holds its value.
- R3: When `cnt_tick` is high, no counter byte is written and the counter equals the active limit, the counter becomes 0x0000 at the edge and `upd_evt` is high for the cycle that follows.
- R4: A write to address 0 replaces counter bits 15:8 and a write to address 1 replaces bits 7:0 at that edge, with no buffering. A counter write takes precedence over a tick in the same cycle: there is no increment and no wrap.
- R5: A read of address 0 returns the live counter bits 15:8 and captures bits 7:0 into a latch. Until a read of address 1, that read returns the latched byte, whatever the counter does in between. The address 1 read releases the latch.
- R6: A read of address 1 with no capture pending returns the live counter bits 7:0.
- R7: Writes to address 2 and address 3 set bits 15:8 and bits 7:0 of the limit staging register. Reads of address 2 and address 3 return those staging bytes.
- R8: At a wrap (R3) the active limit takes the staging value, unless a high-byte limit write (address 2) has been made and no low-byte limit write (address 3) has followed yet. In that case the active limit is kept.
- R9: A counter above the active limit counts up through 0xFFFF to 0x0000 and raises no update pulse, unless the limit itself is 0xFFFF.
- R10: `reg_rdata` is 0x00 in every cycle where `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count enable for this cycle |
| reg_addr | input | 2 | Byte address: 0 count high, 1 count low, 2 limit high, 3 limit low |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address and state |
| upd_evt | output | 1 | One-cycle pulse after a wrap |

## Verification
Read data is combinational, so a byte read returns the state left by the previous edge within the same cycle, while the latch capture, the byte writes and the wraps take effect at the edge that closes the access cycle. `upd_evt` is registered and rises one cycle after the edge on which the counter met the limit. A period measured between two pulses with a tick on every cycle is therefore limit plus one. The bench drives inputs at the falling edge and compares a behavioural model, advanced at each rising edge, against `reg_rdata` and `upd_evt` one nanosecond after the falling edge. Scenario checks take their values from the same sample points.

// File: rtl/bt16_pkg.sv
package bt16_pkg;
  localparam int BW = 8;
  localparam int CW = 2 * BW;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    A_CNT_HI = 2'd0,
    A_CNT_LO = 2'd1,
    A_LIM_HI = 2'd2,
    A_LIM_LO = 2'd3
  } reg_addr_e;

  function automatic logic hits_limit(logic [CW-1:0] c, logic [CW-1:0] l);
    return c == l;
  endfunction

  function automatic logic [CW-1:0] bump(logic [CW-1:0] c);
    return c + {{(CW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [CW-1:0] put_byte(logic [CW-1:0] w, logic hi, logic [BW-1:0] b);
    logic [CW-1:0] r;
    r = w;
    if (hi) r[CW-1:BW] = b;
    else    r[BW-1:0]  = b;
    return r;
  endfunction
endpackage

// File: rtl/bt16_counter.sv
module bt16_counter
  import bt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wdata,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          upd
);
  logic wr_any;
  assign wr_any = wr_hi | wr_lo;
  assign wrap   = tick & ~wr_any & hits_limit(cnt, lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      upd <= 1'b0;
    end else begin
      upd <= wrap;
      if (wr_hi)       cnt <= put_byte(cnt, 1'b1, wdata);
      else if (wr_lo)  cnt <= put_byte(cnt, 1'b0, wdata);
      else if (wrap)   cnt <= '0;
      else if (tick)   cnt <= bump(cnt);
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_any && !wrap |=> cnt == $past(cnt) + 16'd1);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_any |=> $stable(cnt));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0) && upd);
endmodule

// File: rtl/bt16_rdlatch.sv
module bt16_rdlatch
  import bt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hi,
  input  logic          rd_lo,
  input  logic [BW-1:0] live_lo,
  output logic [BW-1:0] lo_view
);
  logic [BW-1:0] held;
  logic          hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      hold <= 1'b0;
    end else if (rd_hi) begin
      held <= live_lo;
      hold <= 1'b1;
    end else if (rd_lo) begin
      hold <= 1'b0;
    end
  end

  assign lo_view = hold ? held : live_lo;

  p_latch_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !rd_hi |=> $stable(held));
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !rd_hi |=> !hold);
endmodule

// File: rtl/bt16_reload.sv
module bt16_reload
  import bt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wdata,
  input  logic          wrap,
  output logic [CW-1:0] stage,
  output logic [CW-1:0] active
);
  logic lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= '1;
      active <= '1;
      lock   <= 1'b0;
    end else begin
      if (wrap && !lock) active <= stage;
      if (wr_hi) begin
        stage <= put_byte(stage, 1'b1, wdata);
        lock  <= 1'b1;
      end else if (wr_lo) begin
        stage <= put_byte(stage, 1'b0, wdata);
        lock  <= 1'b0;
      end
    end
  end

  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(active));
  p_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> lock);
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import bt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  output logic          upd_evt
);
  logic          wr_cnt_hi, wr_cnt_lo, wr_lim_hi, wr_lim_lo;
  logic          rd_cnt_hi, rd_cnt_lo;
  logic [CW-1:0] cnt, lim_active, lim_stage;
  logic [BW-1:0] lo_view;
  logic          wrap;

  assign wr_cnt_hi = reg_wr & (reg_addr == A_CNT_HI);
  assign wr_cnt_lo = reg_wr & (reg_addr == A_CNT_LO);
  assign wr_lim_hi = reg_wr & (reg_addr == A_LIM_HI);
  assign wr_lim_lo = reg_wr & (reg_addr == A_LIM_LO);
  assign rd_cnt_hi = reg_rd & (reg_addr == A_CNT_HI);
  assign rd_cnt_lo = reg_rd & (reg_addr == A_CNT_LO);

  bt16_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
    .wr_hi(wr_cnt_hi), .wr_lo(wr_cnt_lo), .wdata(reg_wdata),
    .lim(lim_active), .cnt(cnt), .wrap(wrap), .upd(upd_evt)
  );

  bt16_rdlatch u_lat (
    .clk(clk), .rst_n(rst_n), .rd_hi(rd_cnt_hi), .rd_lo(rd_cnt_lo),
    .live_lo(cnt[BW-1:0]), .lo_view(lo_view)
  );

  bt16_reload u_arr (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_lim_hi), .wr_lo(wr_lim_lo),
    .wdata(reg_wdata), .wrap(wrap), .stage(lim_stage), .active(lim_active)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_CNT_HI: reg_rdata = cnt[CW-1:BW];
        A_CNT_LO: reg_rdata = lo_view;
        A_LIM_HI: reg_rdata = lim_stage[CW-1:BW];
        A_LIM_LO: reg_rdata = lim_stage[BW-1:0];
        default:  reg_rdata = '0;
      endcase
    end
  end

  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);
endmodule

// File: tb/byte_timer16_bench.sv
`timescale 1ns/100ps
module byte_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       upd_evt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int got = 0;
  bit got_upd = 1'b0;

  // behavioural model
  int m_cnt = 0, m_stage = 'hFFFF, m_act = 'hFFFF, m_latch = 0;
  bit m_lock = 0, m_hold = 0, m_upd = 0;

  always #2.5 clk = ~clk;

  byte_timer16 u_byte_timer16 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .upd_evt(upd_evt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_stage = 'hFFFF; m_act = 'hFFFF; m_latch = 0;
      m_lock = 0; m_hold = 0; m_upd = 0;
    end else begin
      bit cw, wr;
      int ncnt;
      cw = reg_wr && (reg_addr < 2);
      wr = cnt_tick && !cw && (m_cnt == m_act);
      m_upd = wr;
      if (wr && !m_lock) m_act = m_stage;
      if (reg_rd && reg_addr == 0) begin m_hold = 1; m_latch = m_cnt % 256; end
      else if (reg_rd && reg_addr == 1) m_hold = 0;
      ncnt = m_cnt;
      if (reg_wr && reg_addr == 0) ncnt = (m_cnt % 256) + 256 * reg_wdata;
      else if (reg_wr && reg_addr == 1) ncnt = (m_cnt / 256) * 256 + reg_wdata;
      else if (wr) ncnt = 0;
      else if (cnt_tick) ncnt = (m_cnt + 1) % 65536;
      m_cnt = ncnt;
      if (reg_wr && reg_addr == 2) begin m_stage = (m_stage % 256) + 256 * reg_wdata; m_lock = 1; end
      else if (reg_wr && reg_addr == 3) begin m_stage = (m_stage / 256) * 256 + reg_wdata; m_lock = 0; end
    end
  end

  function automatic int exp_rd();
    if (!reg_rd) return 0;
    case (reg_addr)
      2'd0: return m_cnt / 256;
      2'd1: return m_hold ? m_latch : m_cnt % 256;
      2'd2: return m_stage / 256;
      default: return m_stage % 256;
    endcase
  endfunction

  // every-cycle comparison, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(!reg_rd ? "R10" : (reg_addr < 2 ? "R5" : "R7"), reg_rdata, exp_rd());
      chk("R3", upd_evt, m_upd);
    end
  end

  task automatic cyc(bit t, bit w, bit r, int a, int d);
    @(negedge clk);
    cnt_tick = t; reg_wr = w; reg_rd = r; reg_addr = a[1:0]; reg_wdata = d[7:0];
    #1;
    got = reg_rdata;
    got_upd = upd_evt;
  endtask

  task automatic wr_b(int a, int d); cyc(0, 1, 0, a, d); endtask
  task automatic rd_b(int a);        cyc(0, 0, 1, a, 0); endtask

  task automatic run_to_upd(output int n);
    n = 0;
    do begin
      cyc(1, 0, 0, 0, 0);
      n++;
    end while (!got_upd && n < 100000);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_b(0); chk("R1", got, 0);
    rd_b(1); chk("R1", got, 0);
    rd_b(2); chk("R1", got, 'hFF);
    rd_b(3); chk("R1", got, 'hFF);
    chk("R1", got_upd, 0);
    // R2 counting and holding
    wr_b(1, 'h10);
    repeat (3) cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    rd_b(1); chk("R2", got, 'h13);
    rd_b(1); chk("R2", got, 'h13);
    // R4 write beats tick
    cyc(1, 1, 0, 0, 'hAB);
    rd_b(0); chk("R4", got, 'hAB);
    rd_b(1); chk("R4", got, 'h13);
    // R5 coherent read across low-byte rollover
    wr_b(0, 'h12); wr_b(1, 'hFF);
    cyc(1, 0, 1, 0, 0); chk("R5", got, 'h12);
    repeat (2) cyc(1, 0, 0, 0, 0);
    rd_b(1); chk("R5", got, 'hFF);
    // R6 low byte read with nothing pending is live
    rd_b(1); chk("R6", got, 'h02);
    rd_b(0); chk("R6", got, 'h13);
    // R7 staging readback
    wr_b(2, 'h00); wr_b(3, 'h05);
    rd_b(2); chk("R7", got, 'h00);
    rd_b(3); chk("R7", got, 'h05);
    // R8 transfer on wrap
    wr_b(0, 'hFF); wr_b(1, 'hFF);
    run_to_upd(n);
    run_to_upd(n); chk("R8", n, 6);
    // high-byte-only write leaves active limit alone
    wr_b(2, 'h01);
    run_to_upd(n);
    run_to_upd(n); chk("R8", n, 6);
    // R9 above limit rolls over silently
    wr_b(0, 'hFF); wr_b(1, 'hFE);
    cyc(1, 0, 0, 0, 0); chk("R9", got_upd, 0);
    cyc(1, 0, 0, 0, 0); chk("R9", got_upd, 0);
    cyc(0, 0, 0, 0, 0); chk("R9", got_upd, 0);
    rd_b(0); chk("R9", got, 0);
    rd_b(1); chk("R9", got, 0);
    // completing the limit write releases the transfer
    wr_b(3, 'h02);
    run_to_upd(n);
    run_to_upd(n); chk("R8", n, 'h103);
    // R10 no strobe, no data
    cyc(0, 0, 0, 2, 0); chk("R10", got, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule